// File: doc/BRIEF.md
# GPIO Interrupt Event Detector

This block watches the synchronized levels of one bank of general-purpose I/O lines and turns selected events on them into interrupt requests. Each line carries its own 3-bit event code that selects one of two level conditions or one of three edge conditions. Edges are found by comparing every line with its own value one clock earlier. A detected event sets a pending bit for that line whether or not the line is enabled.

Software owns two pieces of state through a small register bus. The first is an enable mask. It is changed only by write-one-to-set and write-one-to-clear accesses, and it can be read back. The second is the set of pending bits, which is cleared by the same read that returns it, so no acknowledge write is needed. The single interrupt output is high whenever any line is both pending and enabled. Filtering of the pin inputs and storage of the event codes sit outside this block.

The register bus is plain control: one-cycle strobes with no handshake and no back-pressure. The block accepts every strobe it samples. Read data appears on the clock edge that samples the read strobe and holds until the next read.

Top module: `gpio_evt_detect`

## Requirements
- R1: Event code 0 flags a falling edge, 1 a rising edge and 2 either edge. An edge is a difference between a line's current level and the level it had one clock earlier.
- R2: Event code 3 flags a low level and 4 a high level. The pending bit is set again on every cycle the level holds, so it is pending again directly after a clearing read.
- R3: Event codes 5, 6 and 7 never set a pending bit.
- R4: A write to offset 0x20 sets the mask bit of every line whose data bit is 1. Zero data bits leave the mask unchanged.
- R5: A write to offset 0x24 clears the mask bit of every line whose data bit is 1. Zero data bits leave the mask unchanged.
- R6: A read of offset 0x28 returns the mask. The data is valid after the clock edge that samples the read strobe.
- R7: A read of offset 0x2C returns the pending bits and clears them. Reads of any other offset return zero and clear nothing, and writes to 0x2C change nothing.
- R8: An event detected in the same cycle as a clearing read is not lost. It is absent from that read's data and stays pending afterwards.
- R9: Pending bits are recorded for masked and unmasked lines alike. The interrupt output is high exactly when some line is both pending and enabled.
- R10: After reset the mask, the pending bits, the read data and the interrupt are zero. The first cycle after reset reports no edge, whatever level the lines hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl | input | NLINES | Synchronized line levels |
| evt_sel | input | 3*NLINES | Event code per line, line k in bits [3k+2:3k] |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | NLINES | Write data, one bit per line |
| bus_rdata | output | NLINES | Read data, updated by each read |
| irq | output | 1 | Bank interrupt request |

## Verification
The assertions take the bus strobes, the offset and the write data to be known values on every sampled edge while reset is released. They also take each strobe to address exactly one register. The pin levels and event codes may change on any cycle, and the properties allow for that. The bench drives all inputs half a period away from the sampling edge and issues one access per strobe. It parks every line it is not testing on a code that never fires, so the pending bits it reads come only from the line under test.

// File: rtl/gev_pkg.sv
package gev_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    EVT_FALL = 3'd0,
    EVT_RISE = 3'd1,
    EVT_BOTH = 3'd2,
    EVT_LOW  = 3'd3,
    EVT_HIGH = 3'd4
  } evt_code_e;
endpackage

// File: rtl/gev_line_eval.sv
module gev_line_eval
  import gev_pkg::*;
(
  input  logic             cur,
  input  logic             prev,
  input  logic             primed,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);
  logic rise, fall;

  always_comb begin
    rise = primed & ~prev & cur;
    fall = primed & prev & ~cur;
    case (sel)
      EVT_FALL: hit = fall;
      EVT_RISE: hit = rise;
      EVT_BOTH: hit = rise | fall;
      EVT_LOW:  hit = ~cur;
      EVT_HIGH: hit = cur;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/gev_edge_bank.sv
module gev_edge_bank
  import gev_pkg::*;
#(
  parameter int NLINES = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NLINES-1:0]       pins,
  input  logic [NLINES*SEL_W-1:0] sel_flat,
  output logic [NLINES-1:0]       hit
);
  logic [NLINES-1:0] prev_q;
  logic              primed_q;

  // history register and a one-shot flag that blocks edges on the first cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= pins;
      primed_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    gev_line_eval u_eval (
      .cur    (pins[g]),
      .prev   (prev_q[g]),
      .primed (primed_q),
      .sel    (sel_flat[g*SEL_W +: SEL_W]),
      .hit    (hit[g])
    );
  end
endmodule

// File: rtl/gev_mask_reg.sv
module gev_mask_reg #(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [NLINES-1:0] bits,
  output logic [NLINES-1:0] mask
);
  logic [NLINES-1:0] set_v, clr_v;

  always_comb begin
    set_v = set_en ? bits : '0;
    clr_v = clr_en ? bits : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mask <= '0;
    else        mask <= (mask | set_v) & ~clr_v;
  end
endmodule

// File: rtl/gev_status_reg.sv
module gev_status_reg #(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] hit,
  input  logic              rd_clr,
  output logic [NLINES-1:0] status
);
  // a clearing read drops old bits, but events of the same cycle are kept
  always_ff @(posedge clk) begin
    if (!rst_n)      status <= '0;
    else if (rd_clr) status <= hit;
    else             status <= status | hit;
  end
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gev_pkg::*;
#(
  parameter int                NLINES   = 32,
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] OFS_EN   = 8'h20,
  parameter logic [ADDR_W-1:0] OFS_DIS  = 8'h24,
  parameter logic [ADDR_W-1:0] OFS_MASK = 8'h28,
  parameter logic [ADDR_W-1:0] OFS_STAT = 8'h2C
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NLINES-1:0]       pin_lvl,
  input  logic [NLINES*SEL_W-1:0] evt_sel,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [NLINES-1:0]       bus_wdata,
  output logic [NLINES-1:0]       bus_rdata,
  output logic                    irq
);
  logic [NLINES-1:0] line_hit;
  logic [NLINES-1:0] mask_q;
  logic [NLINES-1:0] status_q;
  logic              wr_en, wr_dis, rd_mask, rd_stat;

  always_comb begin
    wr_en   = bus_wr && (bus_addr == OFS_EN);
    wr_dis  = bus_wr && (bus_addr == OFS_DIS);
    rd_mask = bus_rd && (bus_addr == OFS_MASK);
    rd_stat = bus_rd && (bus_addr == OFS_STAT);
  end

  gev_edge_bank #(.NLINES(NLINES)) u_edges (
    .clk      (clk),
    .rst_n    (rst_n),
    .pins     (pin_lvl),
    .sel_flat (evt_sel),
    .hit      (line_hit)
  );

  gev_mask_reg #(.NLINES(NLINES)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (wr_en),
    .clr_en (wr_dis),
    .bits   (bus_wdata),
    .mask   (mask_q)
  );

  gev_status_reg #(.NLINES(NLINES)) u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (line_hit),
    .rd_clr (rd_stat),
    .status (status_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (rd_mask)      bus_rdata <= mask_q;
      else if (rd_stat) bus_rdata <= status_q;
      else              bus_rdata <= '0;
    end
  end

  assign irq = |(status_q & mask_q);
endmodule

// File: rtl/gpio_evt_detect_chk.sv
module gpio_evt_detect_chk #(
  parameter int                NLINES   = 32,
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] OFS_EN   = 8'h20,
  parameter logic [ADDR_W-1:0] OFS_DIS  = 8'h24,
  parameter logic [ADDR_W-1:0] OFS_STAT = 8'h2C
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wr,
  input logic                  bus_rd,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [NLINES-1:0]     bus_wdata,
  input logic [NLINES-1:0]     bus_rdata,
  input logic                  irq,
  input logic [NLINES*3-1:0]   evt_sel,
  input logic [NLINES-1:0]     hit,
  input logic [NLINES-1:0]     mask,
  input logic [NLINES-1:0]     status
);
  logic [NLINES-1:0] dead_code;
  logic              c_wr_en, c_wr_dis, c_rd_stat;

  always_comb begin
    for (int i = 0; i < NLINES; i++) dead_code[i] = evt_sel[i*3 +: 3] > 3'd4;
    c_wr_en   = bus_wr && (bus_addr == OFS_EN);
    c_wr_dis  = bus_wr && (bus_addr == OFS_DIS);
    c_rd_stat = bus_rd && (bus_addr == OFS_STAT);
  end

  // R3
  dead_code_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit & dead_code) == '0);

  // R4
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_wr_en && !c_wr_dis |=> (mask & $past(bus_wdata)) == $past(bus_wdata));

  // R5
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_wr_dis |=> (mask & $past(bus_wdata)) == '0);

  // R7
  stat_readout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_rd_stat |=> bus_rdata == $past(status));

  // R7
  stat_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_rd_stat && hit == '0 |=> status == '0);

  // R8
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !c_rd_stat |=> (status & $past(status)) == $past(status));

  // R9
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask == '0 |-> !irq);

  // R9
  irq_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status == '0 |-> !irq);
endmodule

bind gpio_evt_detect gpio_evt_detect_chk #(
  .NLINES   (NLINES),
  .ADDR_W   (ADDR_W),
  .OFS_EN   (OFS_EN),
  .OFS_DIS  (OFS_DIS),
  .OFS_STAT (OFS_STAT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .evt_sel   (evt_sel),
  .hit       (line_hit),
  .mask      (mask_q),
  .status    (status_q)
);

// File: tb/tb_gpio_evt_detect.sv
`timescale 1ns/1ps
module tb_gpio_evt_detect;
  localparam int N = 32;
  localparam logic [7:0] A_EN = 8'h20, A_DIS = 8'h24, A_MSK = 8'h28, A_ST = 8'h2C;
  // {code[2:0], level before, level after, expected pending}
  localparam int NV = 14;
  localparam logic [5:0] VEC [NV] = '{
    {3'd0, 1'b1, 1'b0, 1'b1}, {3'd0, 1'b0, 1'b1, 1'b0},
    {3'd1, 1'b0, 1'b1, 1'b1}, {3'd1, 1'b1, 1'b0, 1'b0},
    {3'd2, 1'b0, 1'b1, 1'b1}, {3'd2, 1'b1, 1'b0, 1'b1},
    {3'd2, 1'b1, 1'b1, 1'b0}, {3'd3, 1'b1, 1'b0, 1'b1},
    {3'd3, 1'b1, 1'b1, 1'b0}, {3'd4, 1'b0, 1'b1, 1'b1},
    {3'd4, 1'b0, 1'b0, 1'b0}, {3'd5, 1'b0, 1'b1, 1'b0},
    {3'd6, 1'b1, 1'b0, 1'b0}, {3'd7, 1'b1, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] pin_lvl = '0;
  logic [N*3-1:0] evt_sel = '1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata;
  logic irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_evt_detect dut (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .evt_sel(evt_sel),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [N-1:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] d;
    int ln;
    logic [2:0] s;
    logic exp;
    string req;

    // R10: line 0 held high with rising-edge code through reset release
    pin_lvl[0] = 1'b1; evt_sel[2:0] = 3'd1;
    idle(4);
    rst_n = 1'b1;
    chk(irq == 1'b0, "R10 irq", N'(irq), '0);
    chk(bus_rdata == '0, "R10 rdata", bus_rdata, '0);
    idle(2);
    rd(A_MSK, d); chk(d == '0, "R10 mask/R6", d, '0);
    rd(A_ST, d);  chk(d == '0, "R10 no first-cycle edge", d, '0);
    evt_sel[2:0] = 3'd7; pin_lvl[0] = 1'b0;

    // vector table: R1 R2 R3 R9
    for (int i = 0; i < NV; i++) begin
      ln = (i * 2) % N;
      s = VEC[i][5:3];
      exp = VEC[i][0];
      req = (s < 3) ? "R1" : (s < 5) ? "R2" : "R3";
      evt_sel[ln*3 +: 3] = 3'd7;
      pin_lvl[ln] = VEC[i][2];
      wr(A_EN, N'(1) << ln);
      idle(2);
      rd(A_ST, d);
      evt_sel[ln*3 +: 3] = s;
      pin_lvl[ln] = VEC[i][1];
      @(negedge clk);
      chk(irq == exp, {req, " R9 irq"}, N'(irq), N'(exp));
      rd(A_ST, d);
      chk(d[ln] == exp, req, N'(d[ln]), N'(exp));
      evt_sel[ln*3 +: 3] = 3'd7;
      wr(A_DIS, N'(1) << ln);
      idle(1);
      rd(A_ST, d);
    end

    // R4 / R5 / R6: set and clear by ones only
    wr(A_EN, 32'h5);  rd(A_MSK, d); chk(d == 32'h5, "R4", d, 32'h5);
    wr(A_EN, 32'h0);  rd(A_MSK, d); chk(d == 32'h5, "R4 zero bits", d, 32'h5);
    wr(A_DIS, 32'h0); rd(A_MSK, d); chk(d == 32'h5, "R5 zero bits", d, 32'h5);
    wr(A_DIS, 32'h1); rd(A_MSK, d); chk(d == 32'h4, "R5", d, 32'h4);
    wr(A_DIS, 32'h4); rd(A_MSK, d); chk(d == 32'h0, "R5 all", d, 32'h0);

    // R7 / R9: line 3 left pending while masked
    evt_sel[9 +: 3] = 3'd4; pin_lvl[3] = 1'b1;
    idle(2);
    evt_sel[9 +: 3] = 3'd7; pin_lvl[3] = 1'b0;
    idle(1);
    chk(irq == 1'b0, "R9 masked pending", N'(irq), '0);
    wr(A_ST, '1);
    rd(8'h00, d); chk(d == '0, "R7 unmapped read", d, '0);
    wr(A_EN, 32'h8);
    chk(irq == 1'b1, "R9 enabled pending", N'(irq), 1);
    rd(A_ST, d); chk(d == 32'h8, "R7 status kept", d, 32'h8);
    chk(irq == 1'b0, "R9 after clear", N'(irq), 0);
    rd(A_ST, d); chk(d == '0, "R7 cleared", d, '0);
    wr(A_DIS, 32'h8);

    // R8: rising edge on line 5 in the same cycle as a clearing read
    evt_sel[15 +: 3] = 3'd1; pin_lvl[5] = 1'b0;
    idle(2);
    rd(A_ST, d);
    pin_lvl[5] = 1'b1;
    rd(A_ST, d); chk(d[5] == 1'b0, "R8 not in same read", d, '0);
    rd(A_ST, d); chk(d == 32'h20, "R8 kept pending", d, 32'h20);
    evt_sel[15 +: 3] = 3'd7;

    // R2: level-high line 6 returns after clearing reads
    evt_sel[18 +: 3] = 3'd4; pin_lvl[6] = 1'b1;
    idle(2);
    rd(A_ST, d); chk(d == 32'h40, "R2 first read", d, 32'h40);
    rd(A_ST, d); chk(d == 32'h40, "R2 reappears", d, 32'h40);
    pin_lvl[6] = 1'b0;
    idle(1);
    rd(A_ST, d); chk(d == 32'h40, "R2 stays until read", d, 32'h40);
    rd(A_ST, d); chk(d == '0, "R2 gone after level drops", d, '0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule